// File: doc/BRIEF.md
# Pseudo-static RAM write bridge

This block turns single-cycle write requests from a synchronous on-chip bus into timed write cycles on a 16-bit asynchronous pseudo-static RAM. A request carries an address, a data word and a two-bit byte mask. It is taken through a valid/ready handshake. The bridge then runs the memory's control strobes: a pair of chip selects (one active low, one active high), the write strobe, the output-enable strobe and the upper and lower byte strobes. It also drives the address and the data word, with an output enable for the pad tri-state buffer. Each minimum time is turned into a whole number of clock cycles at elaboration, from the clock period and the chosen speed grade (grade 0 is the fast part, grade 1 the slow one). For any time t in ns this count is ceil(t / clock period).

The memory writes only while every strobe is active at once. The bridge therefore starts the chip select, the write strobe and the byte strobes on the same clock edge, and ends the write by releasing the write and byte strobes together. Chip select stays active across back-to-back writes to save cycles. The memory does not tolerate a select held active for long, so an age counter watches it. Once the select is too old to fit another full write, the bridge drops it for the minimum deselect time before it accepts more work. Read requests are never accepted.

Top module: `psram_wr_bridge`

## Requirements
- R1: While reset is active and directly after it, the select pair is inactive (active-low select high, active-high select low). The write, output-enable and both byte strobes are high, the data output enable is low and reqReady is low when no write is offered.
- R2: On the clock edge after a handshake, the select pair becomes active, the write strobe falls and the masked byte strobes fall, all on that same edge. The request address appears on memAddr on that edge and stays there until the cycle ends.
- R3: The write strobe stays low for exactly ceil(pulse time / clock period) cycles. The pulse time is 45 ns for grade 0 and 60 ns for grade 1, which gives 5 and 6 cycles at a 10 ns clock.
- R4: memDqOe rises one cycle after the write strobe falls and falls one cycle after the write strobe rises. While it is high, memDqOut equals the request data. This gives at least ceil(data setup / clock period) cycles of valid data before the write strobe rises, with a data setup of 25 ns for grade 0 and 30 ns for grade 1.
- R5: When no deselect gap is due, reqReady returns a full cycle count after the handshake. The count is the larger of ceil(cycle time / clock period) and the pulse count plus one, with a cycle time of 55 ns for grade 0 and 70 ns for grade 1. At a 10 ns clock this is 6 and 7 cycles.
- R6: The chip select never stays active for floor(CS_MAX_NS / clock period) cycles or more. The select age is the number of clock edges since the select was asserted. When the bridge is idle and this age has reached that limit minus the cycle count minus 2, the select is dropped for ceil(CS_HIGH_NS / clock period) cycles. reqReady is low while this is due and while the gap lasts.
- R7: The output-enable strobe stays high at all times.
- R8: While reqWrite is low, reqReady is low and no strobe moves, whatever reqValid does.
- R9: Mask bit 1 (active high) selects the upper byte strobe and mask bit 0 the lower one. A selected byte strobe is low exactly while the write strobe is low. Both byte strobes are high at all other times.
- R10: A write that is accepted while the select is still active and below the age threshold keeps the select asserted with no high cycle between the two writes.
- R11: A write starts only after a cycle in which reqValid, reqWrite and reqReady are all high, and each such cycle starts exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqWrite | input | 1 | 1 = write request, 0 = read request (refused) |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte mask, bit 1 upper byte, bit 0 lower byte, active high |
| reqReady | output | 1 | Bridge takes the request in this cycle |
| memAddr | output | ADDR_W | Memory address bus |
| memDqOut | output | DATA_W | Data toward the memory pads |
| memDqOe | output | 1 | Pad tri-state enable for memDqOut, high drives the bus |
| memSelN | output | 1 | Active-low chip select |
| memSelP | output | 1 | Active-high chip select |
| memWrN | output | 1 | Active-low write strobe |
| memOutEnN | output | 1 | Active-low output enable, held high |
| memHiN | output | 1 | Active-low upper byte strobe |
| memLoN | output | 1 | Active-low lower byte strobe |

## Verification
The delicate cycle is the one in which the select age reaches its threshold while a new write request is already waiting. In that cycle the bridge must refuse the request and drop the select instead of starting another write. A steady stream of back-to-back writes with a shortened select limit forces this cycle several times, at both speed grades. A behavioural reference model judges each occurrence on every clock: it expects reqReady low, the select released for the gap, and the waiting request taken only after the gap, with its data intact. A second, quieter collision is the write strobe rising while the data bus is still driven. This is checked by the one-cycle release of memDqOe on every write.

// File: rtl/psram_wr_pkg.sv
package psram_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PULSE,
    ST_RECOVER,
    ST_GAP
  } wrState_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic csOn;     // chip select pair active
    logic weOn;     // write strobe (and byte strobes) active
    logic dqDrive;  // data pads driven
    logic load;     // capture request fields this edge
  } wrStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int cycleNs(input int grade);
    return (grade == 0) ? 55 : 70;
  endfunction

  function automatic int pulseNs(input int grade);
    return (grade == 0) ? 45 : 60;
  endfunction

  function automatic int setupNs(input int grade);
    return (grade == 0) ? 25 : 30;
  endfunction

endpackage

// File: rtl/psram_wr_ctrl.sv
module psram_wr_ctrl
  import psram_wr_pkg::*;
#(
  parameter int WE_CYC    = 5,
  parameter int REC_CYC   = 1,
  parameter int GAP_CYC   = 1,
  parameter int AGE_LIMIT = 1490,
  parameter int CNT_W     = 3,
  parameter int AGE_W     = 11
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      reqReady,
  output wrStrobe_t strobe
);

  wrState_e         state;
  logic [CNT_W-1:0] cnt;
  logic [AGE_W-1:0] csAge;
  logic             csOn;
  logic             weOn;
  logic             dqDrive;
  logic             needGap;
  logic             accept;

  assign needGap  = csOn && (csAge >= AGE_W'(AGE_LIMIT));
  assign reqReady = (state == ST_IDLE) && !needGap && reqWrite;
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      csAge   <= '0;
      csOn    <= 1'b0;
      weOn    <= 1'b0;
      dqDrive <= 1'b0;
    end else begin
      csAge <= csOn ? csAge + 1'b1 : '0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_PULSE;
            cnt   <= CNT_W'(WE_CYC - 1);
            csOn  <= 1'b1;
            weOn  <= 1'b1;
          end else if (needGap) begin
            state <= ST_GAP;
            cnt   <= CNT_W'(GAP_CYC - 1);
            csOn  <= 1'b0;
          end
        end
        ST_PULSE: begin
          dqDrive <= 1'b1;
          if (cnt == '0) begin
            weOn  <= 1'b0;
            state <= ST_RECOVER;
            cnt   <= CNT_W'(REC_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RECOVER: begin
          dqDrive <= 1'b0;
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strobe.csOn    = csOn;
    strobe.weOn    = weOn;
    strobe.dqDrive = dqDrive;
    strobe.load    = accept;
  end

endmodule

// File: rtl/psram_wr_datapath.sv
module psram_wr_datapath
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int BE_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BE_W-1:0]   reqBe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              memSelN,
  output logic              memSelP,
  output logic              memWrN,
  output logic              memOutEnN,
  output logic              memHiN,
  output logic              memLoN
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [BE_W-1:0]   beQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      beQ   <= '0;
    end else if (strobe.load) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
      beQ   <= reqBe;
    end
  end

  assign memAddr   = addrQ;
  assign memDqOut  = dataQ;
  assign memDqOe   = strobe.dqDrive;
  assign memSelN   = !strobe.csOn;
  assign memSelP   = strobe.csOn;
  assign memWrN    = !strobe.weOn;
  assign memOutEnN = 1'b1;
  assign memHiN    = !(strobe.weOn && beQ[BE_W-1]);
  assign memLoN    = !(strobe.weOn && beQ[0]);

endmodule

// File: rtl/psram_wr_bridge.sv
module psram_wr_bridge
  import psram_wr_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 0,
  parameter int CS_MAX_NS     = 15000,
  parameter int CS_HIGH_NS    = 5,
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic                reqReady,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memDqOut,
  output logic                memDqOe,
  output logic                memSelN,
  output logic                memSelP,
  output logic                memWrN,
  output logic                memOutEnN,
  output logic                memHiN,
  output logic                memLoN
);

  localparam int BE_W      = DATA_W / 8;
  localparam int WC_CYC    = ceilDiv(cycleNs(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int WE_CYC    = ceilDiv(pulseNs(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int SD_CYC    = ceilDiv(setupNs(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int GAP_CYC   = ceilDiv(CS_HIGH_NS, CLK_PERIOD_NS);
  localparam int REC_CYC   = (WC_CYC > WE_CYC + 1) ? WC_CYC - WE_CYC : 1;
  localparam int WR_LEN    = WE_CYC + REC_CYC;
  localparam int CS_LIMIT  = CS_MAX_NS / CLK_PERIOD_NS;
  localparam int AGE_LIMIT = CS_LIMIT - WR_LEN - 2;
  localparam int CNT_MAX   = (WE_CYC > REC_CYC) ? ((WE_CYC > GAP_CYC) ? WE_CYC : GAP_CYC)
                                                : ((REC_CYC > GAP_CYC) ? REC_CYC : GAP_CYC);
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int AGE_W     = $clog2(CS_LIMIT + 1);

  if (WE_CYC - 1 < SD_CYC) begin : gSetupTooShort
    $error("write pulse leaves too little data setup at this clock period");
  end
  if (AGE_LIMIT < 1) begin : gSelectLimitTooShort
    $error("chip select limit cannot hold one write cycle");
  end

  wrStrobe_t strobe;

  psram_wr_ctrl #(
    .WE_CYC   (WE_CYC),
    .REC_CYC  (REC_CYC),
    .GAP_CYC  (GAP_CYC),
    .AGE_LIMIT(AGE_LIMIT),
    .CNT_W    (CNT_W),
    .AGE_W    (AGE_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  psram_wr_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .BE_W  (BE_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .reqBe    (reqBe),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .memSelN  (memSelN),
    .memSelP  (memSelP),
    .memWrN   (memWrN),
    .memOutEnN(memOutEnN),
    .memHiN   (memHiN),
    .memLoN   (memLoN)
  );

endmodule

// File: rtl/psram_wr_bridge_chk.sv
module psram_wr_bridge_chk
  import psram_wr_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 0,
  parameter int CS_MAX_NS     = 15000,
  parameter int CS_HIGH_NS    = 5
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqWrite,
  input logic reqReady,
  input logic memSelN,
  input logic memSelP,
  input logic memWrN,
  input logic memHiN,
  input logic memLoN,
  input logic memDqOe
);

  localparam int WE_CYC   = ceilDiv(pulseNs(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int GAP_CYC  = ceilDiv(CS_HIGH_NS, CLK_PERIOD_NS);
  localparam int CS_LIMIT = CS_MAX_NS / CLK_PERIOD_NS;
  localparam int RUN_W    = $clog2(CS_LIMIT + 2) + 1;

  logic [RUN_W-1:0] lowCnt;
  logic [RUN_W-1:0] selRun;
  logic [RUN_W-1:0] highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      selRun  <= '0;
      highRun <= RUN_W'(GAP_CYC);
    end else begin
      lowCnt  <= memWrN ? '0 : lowCnt + 1'b1;
      selRun  <= memSelN ? '0 : selRun + 1'b1;
      if (!memSelN)                      highRun <= '0;
      else if (highRun < RUN_W'(GAP_CYC)) highRun <= highRun + 1'b1;
    end
  end

  assert_write_overlap_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWrN) |-> (!memSelN && memSelP && (!memHiN || !memLoN)));

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrN) |-> (lowCnt == RUN_W'(WE_CYC)));

  assert_drive_after_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWrN) |=> memDqOe);

  assert_release_after_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrN) |=> !memDqOe);

  assert_select_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    selRun < RUN_W'(CS_LIMIT));

  assert_select_high_time_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memSelN) |-> (highRun >= RUN_W'(GAP_CYC)));

  assert_read_refused_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |-> !reqReady);

  assert_start_needs_handshake_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWrN) |-> $past(reqValid && reqWrite && reqReady));

endmodule

bind psram_wr_bridge psram_wr_bridge_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .SPEED_GRADE  (SPEED_GRADE),
  .CS_MAX_NS    (CS_MAX_NS),
  .CS_HIGH_NS   (CS_HIGH_NS)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqWrite(reqWrite),
  .reqReady(reqReady),
  .memSelN (memSelN),
  .memSelP (memSelP),
  .memWrN  (memWrN),
  .memHiN  (memHiN),
  .memLoN  (memLoN),
  .memDqOe (memDqOe)
);

// File: tb/psram_wr_bridge_tb_top.sv
`timescale 1ns/1ps

module psram_wr_lane #(
  parameter int SPEED_GRADE = 0
) (
  input  logic clk,
  input  logic rstN,
  output logic done
);

  localparam int TCLK    = 10;
  localparam int SELMAX  = 300;
  localparam int SELHIGH = 5;
  localparam int PULSE   = ((SPEED_GRADE == 0 ? 45 : 60) + TCLK - 1) / TCLK;
  localparam int CYCRAW  = ((SPEED_GRADE == 0 ? 55 : 70) + TCLK - 1) / TCLK;
  localparam int CYC     = (CYCRAW > PULSE + 1) ? CYCRAW : PULSE + 1;
  localparam int LIM     = SELMAX / TCLK;
  localparam int THRESH  = LIM - CYC - 2;
  localparam int HIGHMIN = (SELHIGH + TCLK - 1) / TCLK;

  int checks = 0;
  int errors = 0;

  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [19:0] reqAddr  = '0;
  logic [15:0] reqData  = '0;
  logic [1:0]  reqBe    = '0;
  logic        reqReady;
  logic [19:0] memAddr;
  logic [15:0] memDqOut;
  logic        memDqOe, memSelN, memSelP, memWrN, memOutEnN, memHiN, memLoN;

  psram_wr_bridge #(
    .CLK_PERIOD_NS(TCLK),
    .SPEED_GRADE  (SPEED_GRADE),
    .CS_MAX_NS    (SELMAX),
    .CS_HIGH_NS   (SELHIGH)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .reqBe(reqBe), .reqReady(reqReady),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memSelN(memSelN), .memSelP(memSelP), .memWrN(memWrN),
    .memOutEnN(memOutEnN), .memHiN(memHiN), .memLoN(memLoN)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s grade%0d t=%0t actual=%0h expected=%0h", tag, SPEED_GRADE, $time, act, exp);
    end
  endtask

  // behavioural reference model: phase since acceptance, select age, gap left
  bit          mBusy;
  int          mPhase;
  bit          mSel;
  int          mAge;
  int          mGapLeft;
  logic [19:0] mAddr;
  logic [15:0] mData;
  logic [1:0]  mBe;
  int          writesDone;

  function automatic bit readyModel();
    return !mBusy && (mGapLeft == 0) && !(mSel && mAge >= THRESH) && reqWrite;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mPhase = 0; mSel = 0; mAge = 0; mGapLeft = 0;
      mAddr = '0; mData = '0; mBe = '0; writesDone = 0;
    end else begin
      int nextAge;
      nextAge = mSel ? mAge + 1 : 0;
      if (mBusy) begin
        mPhase++;
        if (mPhase == CYC) begin mBusy = 0; writesDone++; end
      end else if (mGapLeft > 0) begin
        mGapLeft--;
      end else if (reqValid && readyModel()) begin
        mBusy = 1; mPhase = 0; mSel = 1;
        mAddr = reqAddr; mData = reqData; mBe = reqBe;
      end else if (mSel && mAge >= THRESH) begin
        mSel = 0; mGapLeft = HIGHMIN;
      end
      mAge = nextAge;
    end
  end

  int runLen  = 0;
  int highLen = 1000;
  int gapsSeen = 0;

  always begin
    @(negedge clk);
    #2;
    if (rstN) begin
      bit wrWin, dqWin, expRdy;
      wrWin  = mBusy && (mPhase < PULSE);
      dqWin  = mBusy && (mPhase >= 1) && (mPhase <= PULSE);
      expRdy = readyModel();
      if (reqValid && !reqWrite) chk(reqReady == 1'b0, "R8 ready", reqReady, 0);
      else chk(reqReady == expRdy, "R5 R6 R11 ready", reqReady, expRdy);
      chk(memSelN == !mSel, "R6 R10 select low", memSelN, !mSel);
      chk(memSelP == mSel, "R6 R10 select high", memSelP, mSel);
      chk(memWrN == !wrWin, "R3 write strobe", memWrN, !wrWin);
      chk(memHiN == !(wrWin && mBe[1]), "R9 upper strobe", memHiN, !(wrWin && mBe[1]));
      chk(memLoN == !(wrWin && mBe[0]), "R9 lower strobe", memLoN, !(wrWin && mBe[0]));
      chk(memOutEnN == 1'b1, "R7 output enable", memOutEnN, 1);
      chk(memDqOe == dqWin, "R4 drive enable", memDqOe, dqWin);
      if (dqWin) chk(memDqOut == mData, "R4 data", memDqOut, mData);
      if (mBusy) chk(memAddr == mAddr, "R2 address", memAddr, mAddr);
      if (!memSelN) begin
        if (runLen == 0) chk(highLen >= HIGHMIN, "R6 high time", highLen, HIGHMIN);
        runLen++;
        highLen = 0;
        chk(runLen < LIM, "R6 select run", runLen, LIM - 1);
      end else begin
        if (runLen > 0) gapsSeen++;
        runLen = 0;
        highLen++;
      end
    end
  end

  task automatic sendWrite(input logic [19:0] a, input logic [15:0] d, input logic [1:0] b);
    bit r;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqData = d; reqBe = b;
    forever begin
      #1 r = reqReady;
      @(negedge clk);
      if (r) break;
    end
    reqValid = 1'b0;
  endtask

  initial begin
    done = 1'b0;
    @(posedge rstN);
    @(negedge clk);
    #2;
    // R1 reset levels
    chk(memSelN == 1'b1 && memSelP == 1'b0, "R1 select idle", {memSelN, memSelP}, 2'b10);
    chk(memWrN && memHiN && memLoN && memOutEnN, "R1 strobes idle",
        {memWrN, memHiN, memLoN, memOutEnN}, 4'hf);
    chk(memDqOe == 1'b0 && reqReady == 1'b0, "R1 bus and ready", {memDqOe, reqReady}, 0);
    // R8 read request is refused
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 20'h12345;
    repeat (6) @(negedge clk);
    #2 chk(memWrN && memSelN, "R8 no strobe after read", {memWrN, memSelN}, 2'b11);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    // single write, both bytes
    sendWrite(20'h0a5a5, 16'hbeef, 2'b11);
    repeat (CYC + 2) @(negedge clk);
    // R10 back to back, upper only then lower only
    sendWrite(20'h00011, 16'h1234, 2'b10);
    sendWrite(20'h00012, 16'h5678, 2'b01);
    repeat (CYC + 1) @(negedge clk);
    // R6 long stream drives the select into its limit
    for (int i = 0; i < 14; i++)
      sendWrite(20'($urandom), 16'($urandom), 2'(i % 3 + 1));
    // idle with select active until the age rule drops it
    repeat (LIM + 10) @(negedge clk);
    #2;
    chk(gapsSeen >= 3, "R6 gaps observed", gapsSeen, 3);
    chk(writesDone == 17, "R11 one write per handshake", writesDone, 17);
    chk(memSelN == 1'b1, "R6 select dropped when idle", memSelN, 1);
    done = 1'b1;
  end

endmodule

module psram_wr_bridge_tb_top;

  logic clk  = 1'b0;
  logic rstN = 1'b0;
  logic doneFast, doneSlow;
  bit   timedOut = 0;

  always #5 clk = ~clk;

  psram_wr_lane #(.SPEED_GRADE(0)) laneFast (.clk(clk), .rstN(rstN), .done(doneFast));
  psram_wr_lane #(.SPEED_GRADE(1)) laneSlow (.clk(clk), .rstN(rstN), .done(doneSlow));

  initial begin
    int totalChecks, totalErrors;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    fork
      begin
        wait (doneFast === 1'b1 && doneSlow === 1'b1);
      end
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    disable fork;
    totalChecks = laneFast.checks + laneSlow.checks + 1;
    totalErrors = laneFast.errors + laneSlow.errors;
    if (timedOut) begin
      totalErrors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", totalChecks, totalErrors);
    $finish;
  end

endmodule